// File: doc/BRIEF.md
# Word, Range and Transition Event Recognizer Bank

This block sits between the sampled input channels of a logic analyzer and its trigger sequencer. On every acquisition clock it takes one sampled word. From that word it produces one event flag per recognizer. Each flag is registered and is valid for the one cycle that follows the sample.

The bank holds three kinds of recognizer:

- Sixteen word recognizers. Each one compares the sample against a pattern, but only on the bits its care mask selects.
- Four range recognizers. Each one gathers a selectable group of channels into a single unsigned value and tests it against a lower and an upper bound.
- One transition detector. It flags any change on the channels it is enabled for.

Two further event types need no setup. The "anything" event is always true. The channel-level event is the registered sample itself, so the sequencer can test any single channel.

All patterns, masks, bounds, group selections and the transition enable are loaded through a write port with an address, a data word and a write strobe. A write changes the recognizers starting with the next sample. The sample taken in the same cycle as the write still sees the old setting.

Top module: `event_bank`

## Requirements
- R1: While reset is asserted, every output is 0. Reset also clears all configuration (patterns, masks, bounds, groups and the transition enable) to 0.
- R2: Word recognizer k flags when `((sample ^ pattern_k) & mask_k) == 0`. Bits whose mask is 0 are ignored, so an all-zero mask matches every sample.
- R3: The 16 word recognizers are independent, and each has its own outputs and registers. `wordHit[k]` is recognizer k. Its pattern is at address k and its mask at address 16+k.
- R4: Range recognizer r flags when `lower_r <= value_r <= upper_r` (unsigned, inclusive at both ends). Its lower bound is at address 32+r and its upper bound at address 36+r. `rangeHit[r]` is recognizer r.
- R5: `value_r` is built from the channels selected by group mask r (address 40+r), in ascending channel order. The lowest selected channel becomes bit 0, so a higher channel is always more significant. Bits above the last selected channel are 0.
- R6: `transHit` flags when any channel enabled in the transition mask (address 44) differs between the current sample and the previous one.
- R7: `transHit` is 0 for the first sample after reset, whatever the sample or the enable.
- R8: `anyHit` is 1 for every sample taken after reset is released.
- R9: `chanLevel` equals the sample from one cycle earlier.
- R10: Every output reflects the sample presented in the previous cycle: exactly one register of latency.
- R11: A configuration write affects the sample after the one taken in the write cycle. The sample taken in the write cycle uses the old value.
- R12: A write to any address from 45 upward changes no configuration and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | CH_W | Sampled channel word |
| wrEn | input | 1 | Configuration write strobe |
| wrAddr | input | ADDR_W | Configuration register address |
| wrData | input | CH_W | Configuration write data |
| wordHit | output | NUM_WORD | Word recognizer events |
| rangeHit | output | NUM_RANGE | Range recognizer events |
| transHit | output | 1 | Transition event |
| anyHit | output | 1 | Always-true event after reset |
| chanLevel | output | CH_W | Registered channel levels (channel event) |

## Verification
Two kinds of collision can happen in one cycle, and the bench provokes both.

The first is a configuration write landing on the same cycle as a sample that only the new setting would match. The bench writes a word pattern while presenting exactly that pattern. It expects no hit from that sample, and a hit from the identical sample in the next cycle.

The second is a word match and a transition arising from the same sample. The bench judges both flags in that one cycle, and a behavioural reference model also compares every output on every clock. That model receives a stream of pseudo-random samples with interleaved writes, including writes to unmapped addresses.

// File: rtl/evt_pkg.sv
package evt_pkg;

  // Kind of configuration register addressed by a write
  typedef enum logic [2:0] {
    K_PAT  = 3'd0,
    K_MASK = 3'd1,
    K_LO   = 3'd2,
    K_HI   = 3'd3,
    K_GRP  = 3'd4,
    K_TEN  = 3'd5
  } cfgKind_e;

  localparam int IDX_W = 8;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic             valid;
    cfgKind_e         kind;
    logic [IDX_W-1:0] idx;
  } cfgStrobe_t;

endpackage

// File: rtl/evt_ctrl.sv
module evt_ctrl
  import evt_pkg::*;
#(
  parameter int NUM_WORD  = 16,
  parameter int NUM_RANGE = 4,
  parameter int ADDR_W    = 6
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output cfgStrobe_t        cfgStb
);

  localparam int PAT_BASE  = 0;
  localparam int MASK_BASE = PAT_BASE + NUM_WORD;
  localparam int LO_BASE   = MASK_BASE + NUM_WORD;
  localparam int HI_BASE   = LO_BASE + NUM_RANGE;
  localparam int GRP_BASE  = HI_BASE + NUM_RANGE;
  localparam int TEN_ADDR  = GRP_BASE + NUM_RANGE;

  int addr;

  always_comb begin
    addr         = int'(wrAddr);
    cfgStb.valid = 1'b0;
    cfgStb.kind  = K_PAT;
    cfgStb.idx   = '0;
    if (wrEn) begin
      if (addr < MASK_BASE) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_PAT;
        cfgStb.idx   = IDX_W'(addr - PAT_BASE);
      end else if (addr < LO_BASE) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_MASK;
        cfgStb.idx   = IDX_W'(addr - MASK_BASE);
      end else if (addr < HI_BASE) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_LO;
        cfgStb.idx   = IDX_W'(addr - LO_BASE);
      end else if (addr < GRP_BASE) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_HI;
        cfgStb.idx   = IDX_W'(addr - HI_BASE);
      end else if (addr < TEN_ADDR) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_GRP;
        cfgStb.idx   = IDX_W'(addr - GRP_BASE);
      end else if (addr == TEN_ADDR) begin
        cfgStb.valid = 1'b1;
        cfgStb.kind  = K_TEN;
        cfgStb.idx   = '0;
      end
    end
  end

endmodule

// File: rtl/evt_range_unit.sv
module evt_range_unit #(
  parameter int CH_W = 16
) (
  input  logic [CH_W-1:0] sample,
  input  logic [CH_W-1:0] grpSel,
  input  logic [CH_W-1:0] lowerBound,
  input  logic [CH_W-1:0] upperBound,
  output logic            inRange
);

  logic [CH_W-1:0] packedVal;
  int              pos;

  // Gather the selected channels; a higher channel lands on a higher bit
  always_comb begin
    packedVal = '0;
    pos       = 0;
    for (int i = 0; i < CH_W; i++) begin
      if (grpSel[i]) begin
        packedVal = packedVal | (CH_W'(sample[i]) << pos);
        pos       = pos + 1;
      end
    end
    inRange = (packedVal >= lowerBound) && (packedVal <= upperBound);
  end

endmodule

// File: rtl/evt_datapath.sv
module evt_datapath
  import evt_pkg::*;
#(
  parameter int CH_W      = 16,
  parameter int NUM_WORD  = 16,
  parameter int NUM_RANGE = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CH_W-1:0]      sampleIn,
  input  logic [CH_W-1:0]      wrData,
  input  cfgStrobe_t           cfgStb,
  output logic [NUM_WORD-1:0]  wordHit,
  output logic [NUM_RANGE-1:0] rangeHit,
  output logic                 transHit,
  output logic                 anyHit,
  output logic [CH_W-1:0]      chanLevel
);

  logic [CH_W-1:0] patReg  [NUM_WORD];
  logic [CH_W-1:0] maskReg [NUM_WORD];
  logic [CH_W-1:0] loReg   [NUM_RANGE];
  logic [CH_W-1:0] hiReg   [NUM_RANGE];
  logic [CH_W-1:0] grpReg  [NUM_RANGE];
  logic [CH_W-1:0] transEn;
  logic [CH_W-1:0] prevSample;
  logic            prevValid;

  logic [NUM_WORD-1:0]  wordNow;
  logic [NUM_RANGE-1:0] rangeNow;
  logic                 transNow;

  // Word recognizer configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_WORD; i++) begin
        patReg[i]  <= '0;
        maskReg[i] <= '0;
      end
    end else if (cfgStb.valid) begin
      for (int i = 0; i < NUM_WORD; i++) begin
        if (int'(cfgStb.idx) == i) begin
          if (cfgStb.kind == K_PAT)  patReg[i]  <= wrData;
          if (cfgStb.kind == K_MASK) maskReg[i] <= wrData;
        end
      end
    end
  end

  // Range recognizer and transition configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_RANGE; r++) begin
        loReg[r]  <= '0;
        hiReg[r]  <= '0;
        grpReg[r] <= '0;
      end
      transEn <= '0;
    end else if (cfgStb.valid) begin
      for (int r = 0; r < NUM_RANGE; r++) begin
        if (int'(cfgStb.idx) == r) begin
          if (cfgStb.kind == K_LO)  loReg[r]  <= wrData;
          if (cfgStb.kind == K_HI)  hiReg[r]  <= wrData;
          if (cfgStb.kind == K_GRP) grpReg[r] <= wrData;
        end
      end
      if (cfgStb.kind == K_TEN) transEn <= wrData;
    end
  end

  genvar gw, gr;
  generate
    for (gw = 0; gw < NUM_WORD; gw++) begin : g_word
      assign wordNow[gw] = ((sampleIn ^ patReg[gw]) & maskReg[gw]) == '0;
    end
    for (gr = 0; gr < NUM_RANGE; gr++) begin : g_range
      evt_range_unit #(.CH_W(CH_W)) u_range (
        .sample    (sampleIn),
        .grpSel    (grpReg[gr]),
        .lowerBound(loReg[gr]),
        .upperBound(hiReg[gr]),
        .inRange   (rangeNow[gr])
      );
    end
  endgenerate

  assign transNow = prevValid && (((sampleIn ^ prevSample) & transEn) != '0);

  // Event registers: one cycle from sample to flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordHit    <= '0;
      rangeHit   <= '0;
      transHit   <= 1'b0;
      anyHit     <= 1'b0;
      chanLevel  <= '0;
      prevSample <= '0;
      prevValid  <= 1'b0;
    end else begin
      wordHit    <= wordNow;
      rangeHit   <= rangeNow;
      transHit   <= transNow;
      anyHit     <= 1'b1;
      chanLevel  <= sampleIn;
      prevSample <= sampleIn;
      prevValid  <= 1'b1;
    end
  end

endmodule

// File: rtl/event_bank.sv
module event_bank
  import evt_pkg::*;
#(
  parameter int CH_W      = 16,
  parameter int NUM_WORD  = 16,
  parameter int NUM_RANGE = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CH_W-1:0]      sampleIn,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [CH_W-1:0]      wrData,
  output logic [NUM_WORD-1:0]  wordHit,
  output logic [NUM_RANGE-1:0] rangeHit,
  output logic                 transHit,
  output logic                 anyHit,
  output logic [CH_W-1:0]      chanLevel
);

  cfgStrobe_t cfgStb;

  evt_ctrl #(
    .NUM_WORD (NUM_WORD),
    .NUM_RANGE(NUM_RANGE),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .wrEn  (wrEn),
    .wrAddr(wrAddr),
    .cfgStb(cfgStb)
  );

  evt_datapath #(
    .CH_W     (CH_W),
    .NUM_WORD (NUM_WORD),
    .NUM_RANGE(NUM_RANGE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .sampleIn (sampleIn),
    .wrData   (wrData),
    .cfgStb   (cfgStb),
    .wordHit  (wordHit),
    .rangeHit (rangeHit),
    .transHit (transHit),
    .anyHit   (anyHit),
    .chanLevel(chanLevel)
  );

endmodule

// File: rtl/event_bank_chk.sv
module event_bank_chk #(
  parameter int CH_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [CH_W-1:0] sampleIn,
  input logic            transHit,
  input logic            anyHit,
  input logic [CH_W-1:0] chanLevel
);

  // R8
  anything_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> anyHit);

  // R9
  chan_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> chanLevel == $past(sampleIn));

  // R6
  stable_no_trans_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(sampleIn)) |=> !transHit);

  // R6
  trans_needs_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    transHit |-> $past(sampleIn) != $past(sampleIn, 2));

  // R7
  first_sample_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |=> !transHit);

endmodule

bind event_bank event_bank_chk #(.CH_W(CH_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sampleIn (sampleIn),
  .transHit (transHit),
  .anyHit   (anyHit),
  .chanLevel(chanLevel)
);

// File: tb/test_event_bank.sv
module test_event_bank;

  localparam int CH_W = 16;
  localparam int NW   = 16;
  localparam int NR   = 4;
  localparam int AW   = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CH_W-1:0] sampleIn = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [CH_W-1:0] wrData = '0;
  logic [NW-1:0] wordHit;
  logic [NR-1:0] rangeHit;
  logic          transHit;
  logic          anyHit;
  logic [CH_W-1:0] chanLevel;

  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  event_bank #(.CH_W(CH_W), .NUM_WORD(NW), .NUM_RANGE(NR), .ADDR_W(AW)) i_event_bank (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .wordHit(wordHit), .rangeHit(rangeHit), .transHit(transHit),
    .anyHit(anyHit), .chanLevel(chanLevel)
  );

  // Behavioural reference model
  logic [15:0] mPat [16];
  logic [15:0] mMask[16];
  logic [15:0] mLo  [4];
  logic [15:0] mHi  [4];
  logic [15:0] mGrp [4];
  logic [15:0] mTen;
  logic [15:0] mPrev;
  bit          mHavePrev;
  logic [15:0] eWord, eChan;
  logic [3:0]  eRange;
  logic        eTrans, eAny;

  function automatic logic [15:0] gather(input logic [15:0] s, input logic [15:0] g);
    logic [15:0] v;
    int p;
    v = '0;
    p = 0;
    for (int j = 0; j < 16; j++) begin
      if (g[j]) begin
        v[p] = s[j];
        p++;
      end
    end
    return v;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rstN) begin
      for (int k = 0; k < 16; k++) begin mPat[k] = 0; mMask[k] = 0; end
      for (int k = 0; k < 4; k++) begin mLo[k] = 0; mHi[k] = 0; mGrp[k] = 0; end
      mTen = 0; mPrev = 0; mHavePrev = 0;
      eWord = 0; eRange = 0; eTrans = 0; eAny = 0; eChan = 0;
    end else begin
      for (int k = 0; k < 16; k++)
        eWord[k] = ((sampleIn ^ mPat[k]) & mMask[k]) == 0;
      for (int k = 0; k < 4; k++) begin
        logic [15:0] v;
        v = gather(sampleIn, mGrp[k]);
        eRange[k] = (v >= mLo[k]) && (v <= mHi[k]);
      end
      eTrans = mHavePrev && (((sampleIn ^ mPrev) & mTen) != 0);
      eAny = 1'b1;
      eChan = sampleIn;
      mPrev = sampleIn;
      mHavePrev = 1;
      if (wrEn) begin
        int a;
        a = int'(wrAddr);
        if (a < 16) mPat[a] = wrData;
        else if (a < 32) mMask[a-16] = wrData;
        else if (a < 36) mLo[a-32] = wrData;
        else if (a < 40) mHi[a-36] = wrData;
        else if (a < 44) mGrp[a-40] = wrData;
        else if (a == 44) mTen = wrData;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare with the model on every clock (R2 R4 R6 R8 R9 R10 R12)
  always @(negedge clk) begin
    if (started && !finished) begin
      check("R2/R3 wordHit", 32'(wordHit), 32'(eWord));
      check("R4/R5 rangeHit", 32'(rangeHit), 32'(eRange));
      check("R6 transHit", 32'(transHit), 32'(eTrans));
      check("R8 anyHit", 32'(anyHit), 32'(eAny));
      check("R9 chanLevel", 32'(chanLevel), 32'(eChan));
    end
  end

  task automatic cyc(input logic [15:0] s, input bit we = 0,
                     input logic [5:0] a = 0, input logic [15:0] d = 0);
    sampleIn = s; wrEn = we; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: outputs held at zero during reset
    check("R1 reset wordHit", 32'(wordHit), 0);
    check("R1 reset rangeHit", 32'(rangeHit), 0);
    check("R1 reset flags", {30'd0, transHit, anyHit}, 0);
    rstN = 1'b1;
    cyc(16'h1234, 1, 6'd44, 16'hFFFF);
    // R7: first sample after reset never flags a transition
    check("R7 first sample", 32'(transHit), 0);
    check("R8 anything after reset", 32'(anyHit), 1);
    // R3: independent word slots
    cyc(16'h0000, 1, 6'd0, 16'h00F0);
    cyc(16'h0000, 1, 6'd16, 16'h00F0);
    cyc(16'h0000, 1, 6'd5, 16'hAAAA);
    cyc(16'h0000, 1, 6'd21, 16'hFFFF);
    cyc(16'h0000, 1, 6'd44, 16'h000F);
    // R5: group of channels 2, 13 and 15; value 5 expected for sample 0x8004
    cyc(16'h0000, 1, 6'd40, 16'hA004);
    cyc(16'h0000, 1, 6'd32, 16'h0005);
    cyc(16'h0000, 1, 6'd36, 16'h0005);
    cyc(16'h0000, 1, 6'd41, 16'hFFFF);
    cyc(16'h0000, 1, 6'd33, 16'h0100);
    cyc(16'h0000, 1, 6'd37, 16'h0200);
    // R2 and R6 in the same cycle
    cyc(16'h00F3);
    check("R2 masked word match", 32'(wordHit[0]), 1);
    check("R6 transition same cycle", 32'(transHit), 1);
    check("R3 word5 idle", 32'(wordHit[5]), 0);
    cyc(16'hAAAA);
    check("R3 word5 match", 32'(wordHit[5]), 1);
    cyc(16'h8004);
    check("R5 group order", 32'(rangeHit[0]), 1);
    cyc(16'hA004);
    check("R5 group value 7 misses", 32'(rangeHit[0]), 0);
    // R4 boundaries
    cyc(16'h0100); check("R4 lower edge", 32'(rangeHit[1]), 1);
    cyc(16'h0200); check("R4 upper edge", 32'(rangeHit[1]), 1);
    cyc(16'h00FF); check("R4 below", 32'(rangeHit[1]), 0);
    cyc(16'h0201); check("R4 above", 32'(rangeHit[1]), 0);
    // R11: write and matching sample in the same cycle
    cyc(16'h5555, 1, 6'd5, 16'h5555);
    check("R11 old config in write cycle", 32'(wordHit[5]), 0);
    cyc(16'h5555);
    check("R11 new config next sample", 32'(wordHit[5]), 1);
    // R10: one cycle latency
    cyc(16'h00F0); check("R10 latency hit", 32'(wordHit[0]), 1);
    cyc(16'h0000); check("R10 latency clear", 32'(wordHit[0]), 0);
    // R12: unmapped writes leave everything unchanged
    cyc(16'h0000, 1, 6'd45, 16'hFFFF);
    cyc(16'h0000, 1, 6'd63, 16'hFFFF);
    cyc(16'h0010);
    check("R12 transEn untouched", 32'(transHit), 0);
    cyc(16'h5555);
    check("R12 word5 untouched", 32'(wordHit[5]), 1);
    // Pseudo-random stream with interleaved writes
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (n % 7 == 3) cyc(lfsr, 1, 6'(lfsr[5:0]), {lfsr[7:0], lfsr[15:8]});
      else cyc(lfsr);
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule